// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block receives a three-wire serial audio link as a slave. The bit clock, word select and serial data come from an external transmitter. All three lines are brought into the system clock domain by a synchronizer. Rising edges of the bit clock are found there, and at each one a bit of data is taken. The bits are assembled into a left word and a right word. Each word is presented as a 24-bit signed sample with its most significant bit at bit 23.

A 3-bit format input selects the framing. The choices are the standard delayed-MSB framing (I2S), MSB-justified framing, and LSB-justified framing with 16, 18 or 20 data bits. In the LSB-justified framings the data sits at the end of each half-frame, so the receiver always keeps the most recent bits. It picks the word out when word select changes.

A finished left/right pair leaves through a valid/ready interface. Once `out_valid` is raised, the pair stays unchanged until `out_ready` is high at a clock edge. There is no queue. A pair that completes while an earlier one is still waiting is discarded, and the waiting pair is kept. Because of this the consumer must accept each pair within one frame period.

Top module: `saud_rx`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and both sample outputs are 0 until the first complete pair arrives.
- R2: With format code 0, the word's MSB is the bit taken at the second bit-clock rise after word select changes. Word select low marks the left word and high marks the right word.
- R3: With format code 4, the word's MSB is the bit taken at the first bit-clock rise at which the new word-select level is seen.
- R4: With format codes 1, 2 and 3, the sample is the last 16, 18 or 20 bits before the next word-select change. It is placed in bits 23 down to 24-N, and the lower bits are 0. Bits earlier in the half-frame have no effect.
- R5: In codes 0 and 4, a half-frame longer than 24 bits yields its first 24 bits. Later bits have no effect.
- R6: Format codes 5, 6 and 7 behave exactly as code 0.
- R7: Exactly one pair is offered for each right word that follows a left word. A half-frame that is cut short by reset is never offered.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_left` and `out_right` hold their values. A cycle with both high removes the pair.
- R9: A pair that completes while an earlier pair is waiting unaccepted is dropped, and the waiting pair is kept.
- R10: When a pair completes in the same cycle as the waiting pair is accepted, the new pair is loaded and `out_valid` stays 1.
- R11: A half-frame shorter than the word is handled as follows. In codes 0 and 4 it is padded with zeros at the LSB end. In codes 1 to 3 the received bits are sign-extended from the first bit received to N bits, and the result is then left-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bck_i | input | 1 | Serial bit clock from the transmitter |
| ws_i | input | 1 | Word select, low for left, high for right |
| sd_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 3 | Framing code: 0 I2S, 1/2/3 LSB-justified 16/18/20, 4 MSB-justified |
| out_valid | output | 1 | A left/right pair is offered |
| out_ready | input | 1 | Consumer accepts the offered pair |
| out_left | output | 24 | Left sample, signed, MSB at bit 23 |
| out_right | output | 24 | Right sample, signed, MSB at bit 23 |

## Verification
Completion of a new pair and acceptance of the waiting pair can fall in the same clock cycle. In that cycle the output stage must load the newer pair and keep `out_valid` high, and must not drop either pair. The bench provokes this by holding `out_ready` low while the first pair waits. It then raises `out_ready` for exactly the one cycle in which the closing bit-clock edge of the second pair reaches the output stage. That cycle is counted from the bit-clock rise through the synchronizer, edge detector, deserializer and pair stage. The test passes when the consumer records the first pair and then still finds the second pair on offer.

// File: rtl/saud_rx_pkg.sv
package saud_rx_pkg;

  typedef enum logic [2:0] {
    FMT_I2S   = 3'd0,
    FMT_LSB16 = 3'd1,
    FMT_LSB18 = 3'd2,
    FMT_LSB20 = 3'd3,
    FMT_MSBJ  = 3'd4
  } fmt_e;

  // lead: word boundary trails the word-select change by one bit
  // lsb_mode: word is taken from the end of the half-frame
  typedef struct packed {
    logic       lead;
    logic       lsb_mode;
    logic [4:0] lsb_bits;
  } fmt_cfg_t;

  function automatic fmt_cfg_t decode_fmt(input logic [2:0] code);
    fmt_cfg_t c;
    c = '{lead: 1'b1, lsb_mode: 1'b0, lsb_bits: 5'd0};
    case (fmt_e'(code))
      FMT_LSB16: c = '{lead: 1'b0, lsb_mode: 1'b1, lsb_bits: 5'd16};
      FMT_LSB18: c = '{lead: 1'b0, lsb_mode: 1'b1, lsb_bits: 5'd18};
      FMT_LSB20: c = '{lead: 1'b0, lsb_mode: 1'b1, lsb_bits: 5'd20};
      FMT_MSBJ:  c = '{lead: 1'b0, lsb_mode: 1'b0, lsb_bits: 5'd0};
      default:   c = '{lead: 1'b1, lsb_mode: 1'b0, lsb_bits: 5'd0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/saud_rx_sync.sv
module saud_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/saud_rx_align.sv
module saud_rx_align
  import saud_rx_pkg::*;
#(
  parameter int W  = 24,
  parameter int CW = $clog2(W + 1)
) (
  input  fmt_cfg_t        cfg,
  input  logic [W-1:0]    head,
  input  logic [W-1:0]    tail,
  input  logic [CW-1:0]   cnt,
  output logic [W-1:0]    aligned
);
  logic [CW-1:0] keep;
  logic          fill;
  logic [W-1:0]  ext;
  logic [W-1:0]  lsb_al;
  logic [W-1:0]  msb_al;

  always_comb begin
    // number of trailing bits that really belong to this half-frame
    keep = (cnt < CW'(cfg.lsb_bits)) ? cnt : CW'(cfg.lsb_bits);
    fill = (keep != '0) ? tail[keep - 1'b1] : 1'b0;
    for (int i = 0; i < W; i++) ext[i] = (i < int'(keep)) ? tail[i] : fill;
    lsb_al = ext << (W - int'(cfg.lsb_bits));
    msb_al = (cnt >= CW'(W)) ? head : (head << (W - int'(cnt)));
    aligned = cfg.lsb_mode ? lsb_al : msb_al;
  end
endmodule

// File: rtl/saud_rx_deser.sv
module saud_rx_deser
  import saud_rx_pkg::*;
#(
  parameter int W  = 24,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_rise,
  input  logic          ws_s,
  input  logic          sd_s,
  input  fmt_cfg_t      cfg,
  input  logic [W-1:0]  aligned,
  output logic [W-1:0]  head,
  output logic [W-1:0]  tail,
  output logic [CW-1:0] cnt,
  output logic          word_done,
  output logic          word_ch,
  output logic [W-1:0]  word_data
);
  localparam logic [CW-1:0] CNT_MAX = CW'(W);

  logic ws_d;
  logic lab_prev;
  logic started;
  logic lab;

  // channel the current bit belongs to
  assign lab = cfg.lead ? ws_d : ws_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_d      <= 1'b0;
      lab_prev  <= 1'b0;
      started   <= 1'b0;
      head      <= '0;
      tail      <= '0;
      cnt       <= '0;
      word_done <= 1'b0;
      word_ch   <= 1'b0;
      word_data <= '0;
    end else begin
      word_done <= 1'b0;
      if (bit_rise) begin
        ws_d <= ws_s;
        if (lab != lab_prev) begin
          if (started) begin
            word_done <= 1'b1;
            word_ch   <= lab_prev;
            word_data <= aligned;
          end
          started  <= 1'b1;
          lab_prev <= lab;
          head     <= {{(W-1){1'b0}}, sd_s};
          tail     <= {{(W-1){1'b0}}, sd_s};
          cnt      <= CW'(1);
        end else begin
          if (cnt < CNT_MAX) begin
            head <= {head[W-2:0], sd_s};
            cnt  <= cnt + CW'(1);
          end
          tail <= {tail[W-2:0], sd_s};
        end
      end
    end
  end
endmodule

// File: rtl/saud_rx_pair.sv
module saud_rx_pair #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_done,
  input  logic         word_ch,
  input  logic [W-1:0] word_data,
  output logic         pair_stb,
  output logic [W-1:0] pair_left,
  output logic [W-1:0] pair_right
);
  logic [W-1:0] left_hold;
  logic         have_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_hold  <= '0;
      have_left  <= 1'b0;
      pair_stb   <= 1'b0;
      pair_left  <= '0;
      pair_right <= '0;
    end else begin
      pair_stb <= 1'b0;
      if (word_done) begin
        if (!word_ch) begin
          left_hold <= word_data;
          have_left <= 1'b1;
        end else if (have_left) begin
          pair_stb   <= 1'b1;
          pair_left  <= left_hold;
          pair_right <= word_data;
          have_left  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/saud_rx_oreg.sv
module saud_rx_oreg #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pair_stb,
  input  logic [W-1:0] pair_left,
  input  logic [W-1:0] pair_right,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (pair_stb && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_left  <= pair_left;
      out_right <= pair_right;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/saud_rx.sv
module saud_rx
  import saud_rx_pkg::*;
#(
  parameter int W          = 24,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bck_i,
  input  logic         ws_i,
  input  logic         sd_i,
  input  logic [2:0]   fmt_i,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right
);
  localparam int CW = $clog2(W + 1);

  logic [2:0]    line_s;
  logic          bck_q;
  logic          bit_rise;
  fmt_cfg_t      cfg;
  logic [W-1:0]  head;
  logic [W-1:0]  tail;
  logic [CW-1:0] cnt;
  logic [W-1:0]  aligned;
  logic          word_done;
  logic          word_ch;
  logic [W-1:0]  word_data;
  logic          pair_stb;
  logic [W-1:0]  pair_left;
  logic [W-1:0]  pair_right;

  assign cfg = decode_fmt(fmt_i);

  saud_rx_sync #(.WIDTH(3), .STAGES(SYNC_DEPTH)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({bck_i, ws_i, sd_i}),
    .dout (line_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bck_q <= 1'b0;
    else        bck_q <= line_s[2];
  end

  assign bit_rise = line_s[2] & ~bck_q;

  saud_rx_align #(.W(W), .CW(CW)) u_align (
    .cfg    (cfg),
    .head   (head),
    .tail   (tail),
    .cnt    (cnt),
    .aligned(aligned)
  );

  saud_rx_deser #(.W(W), .CW(CW)) u_deser (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_rise (bit_rise),
    .ws_s     (line_s[1]),
    .sd_s     (line_s[0]),
    .cfg      (cfg),
    .aligned  (aligned),
    .head     (head),
    .tail     (tail),
    .cnt      (cnt),
    .word_done(word_done),
    .word_ch  (word_ch),
    .word_data(word_data)
  );

  saud_rx_pair #(.W(W)) u_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_done (word_done),
    .word_ch   (word_ch),
    .word_data (word_data),
    .pair_stb  (pair_stb),
    .pair_left (pair_left),
    .pair_right(pair_right)
  );

  saud_rx_oreg #(.W(W)) u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .pair_stb  (pair_stb),
    .pair_left (pair_left),
    .pair_right(pair_right),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right)
  );
endmodule

// File: rtl/saud_rx_chk.sv
module saud_rx_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   fmt_i,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_left,
  input logic [W-1:0] out_right,
  input logic         pair_stb,
  input logic [W-1:0] pair_left,
  input logic         word_done,
  input logic         word_ch
);
  assert_reset_empty_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid && out_left == '0 && out_right == '0);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_left) && $stable(out_right));

  assert_drop_new_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb && out_valid && !out_ready |=> $stable(out_left) && $stable(out_right));

  assert_merge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb && out_valid && out_ready |=> out_valid && out_left == $past(pair_left));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb |=> !pair_stb);

  assert_right_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb |-> $past(word_done && word_ch));

  assert_lsb16_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && fmt_i == 3'd1 |-> out_left[7:0] == 8'd0 && out_right[7:0] == 8'd0);
endmodule

bind saud_rx saud_rx_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fmt_i    (fmt_i),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_left (out_left),
  .out_right(out_right),
  .pair_stb (pair_stb),
  .pair_left(pair_left),
  .word_done(word_done),
  .word_ch  (word_ch)
);

// File: tb/saud_rx_test.sv
`timescale 1ns/1ps
module saud_rx_test;
  localparam int H = 6;   // system clocks per bit-clock phase

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bck = 1'b0;
  logic        ws = 1'b0;
  logic        sd = 1'b0;
  logic [2:0]  fmt = 3'd0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [23:0] out_left;
  logic [23:0] out_right;

  int n_chk = 0;
  int n_err = 0;

  logic [23:0] smp_l [4];
  logic [23:0] smp_r [4];
  int nf = 1;
  int hb = 24;
  int hook_p = -1;
  logic [23:0] got_l [8];
  logic [23:0] got_r [8];
  int got_n = 0;

  always #4 clk = ~clk;

  saud_rx uut (
    .clk(clk), .rst_n(rst_n), .bck_i(bck), .ws_i(ws), .sd_i(sd), .fmt_i(fmt),
    .out_valid(out_valid), .out_ready(out_ready), .out_left(out_left), .out_right(out_right)
  );

  // consumer: records each handshake, sampled after the bench's negedge updates
  always begin
    @(negedge clk);
    #1;
    if (rst_n && out_valid && out_ready && got_n < 8) begin
      got_l[got_n] = out_left;
      got_r[got_n] = out_right;
      got_n++;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int lsb_n_of(input logic [2:0] code);
    case (code)
      3'd1: return 16;
      3'd2: return 18;
      3'd3: return 20;
      default: return 0;
    endcase
  endfunction

  function automatic logic [23:0] exp_of(input logic [23:0] s, input logic [2:0] code, input int hb_);
    int n;
    int m;
    logic [23:0] w;
    logic [23:0] e;
    n = lsb_n_of(code);
    if (n == 0) begin
      if (hb_ >= 24) return s;
      return (s >> (24 - hb_)) << (24 - hb_);
    end
    w = s >> (24 - n);
    m = (hb_ < n) ? hb_ : n;
    for (int i = 0; i < 24; i++) e[i] = (i < m) ? w[i] : w[m-1];
    return e << (24 - n);
  endfunction

  // half 0 is a right preamble, halves 1..2nf carry frames, the last is a left tail
  function automatic logic ch_at(input int p);
    int k;
    k = p / hb;
    if (k == 0) return 1'b1;
    return ((k - 1) % 2) != 0;
  endfunction

  function automatic logic bit_at(input int p);
    int k;
    int j;
    int n;
    int f;
    int pos;
    logic [23:0] s;
    k = p / hb;
    j = p % hb;
    n = lsb_n_of(fmt);
    if (k == 0 || k == 2 * nf + 1) return 1'b1;
    f = (k - 1) / 2;
    s = (((k - 1) % 2) == 0) ? smp_l[f] : smp_r[f];
    if (n == 0) return (j < 24) ? s[23 - j] : 1'b1;
    pos = hb - 1 - j;
    if (pos < n) return s[24 - n + pos];
    return 1'b1;
  endfunction

  task automatic do_reset(input logic [2:0] code, input logic rdy);
    rst_n = 1'b0;
    bck = 1'b0; ws = 1'b0; sd = 1'b0;
    fmt = code;
    out_ready = rdy;
    hook_p = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    got_n = 0;
  endtask

  task automatic drive_stream();
    int total;
    logic lead;
    total = (2 * nf + 2) * hb;
    lead = !(fmt >= 3'd1 && fmt <= 3'd4);
    for (int p = 0; p < total; p++) begin
      ws = lead ? ch_at((p + 1 < total) ? p + 1 : p) : ch_at(p);
      sd = bit_at(p);
      repeat (H) @(negedge clk);
      bck = 1'b1;
      if (p == hook_p) begin
        // ready for exactly the cycle in which this edge reaches the output stage
        repeat (4) @(negedge clk);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        repeat (H - 5) @(negedge clk);
      end else begin
        repeat (H) @(negedge clk);
      end
      bck = 1'b0;
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic check_pairs(input string req, input int hb_);
    chk("R7", "pair count", got_n, nf);
    for (int f = 0; f < nf; f++) begin
      chk(req, "left", got_l[f], exp_of(smp_l[f], fmt, hb_));
      chk(req, "right", got_r[f], exp_of(smp_r[f], fmt, hb_));
    end
  endtask

  task automatic load_set();
    smp_l[0] = 24'h800001; smp_r[0] = 24'h7FFFFE;
    smp_l[1] = 24'hA5C3E1; smp_r[1] = 24'h123456;
    smp_l[2] = 24'hFFFFFF; smp_r[2] = 24'h000001;
    smp_l[3] = 24'h5A5A5A; smp_r[3] = 24'hC0FFEE;
  endtask

  task automatic t_reset_r1();
    do_reset(3'd0, 1'b1);
    chk("R1", "valid after reset", out_valid, 0);
    chk("R1", "left after reset", out_left, 0);
    chk("R1", "right after reset", out_right, 0);
  endtask

  task automatic t_i2s_r2();
    load_set(); nf = 3; hb = 24;
    do_reset(3'd0, 1'b1);
    drive_stream();
    check_pairs("R2", hb);
  endtask

  task automatic t_msb_long_r3_r5();
    load_set(); nf = 3; hb = 32;
    do_reset(3'd4, 1'b1);
    drive_stream();
    check_pairs("R3", hb);
    chk("R5", "trailing bits ignored", got_l[1], smp_l[1]);
  endtask

  task automatic t_lsb_r4();
    load_set(); nf = 2; hb = 32;
    for (int c = 1; c <= 3; c++) begin
      do_reset(3'(c), 1'b1);
      drive_stream();
      check_pairs("R4", hb);
    end
  endtask

  task automatic t_unused_r6();
    load_set(); nf = 2; hb = 32;
    do_reset(3'd6, 1'b1);
    drive_stream();
    check_pairs("R6", hb);
  endtask

  task automatic t_short_r11();
    load_set(); nf = 2; hb = 16;
    do_reset(3'd4, 1'b1);
    drive_stream();
    check_pairs("R11", hb);
    do_reset(3'd3, 1'b1);
    drive_stream();
    check_pairs("R11", hb);
  endtask

  task automatic t_backpressure_r8_r9();
    load_set(); nf = 2; hb = 24;
    do_reset(3'd0, 1'b0);
    drive_stream();
    chk("R8", "valid held", out_valid, 1);
    chk("R9", "first left kept", out_left, smp_l[0]);
    chk("R9", "first right kept", out_right, smp_r[0]);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    @(negedge clk);
    chk("R8", "valid after accept", out_valid, 0);
    chk("R9", "one pair taken", got_n, 1);
  endtask

  task automatic t_same_cycle_r10();
    load_set(); nf = 2; hb = 24;
    do_reset(3'd4, 1'b0);
    hook_p = (1 + 2 * nf) * hb;
    drive_stream();
    chk("R10", "first pair taken at merge", got_n, 1);
    chk("R10", "first pair left", got_l[0], smp_l[0]);
    chk("R10", "valid stays", out_valid, 1);
    chk("R10", "new left offered", out_left, smp_l[1]);
    chk("R10", "new right offered", out_right, smp_r[1]);
    out_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", "second pair taken", got_n, 2);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    t_reset_r1();
    t_i2s_r2();
    t_msb_long_r3_r5();
    t_lsb_r4();
    t_unused_r6();
    t_short_r11();
    t_backpressure_r8_r9();
    t_same_cycle_r10();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end
endmodule